// File: doc/BRIEF.md
# CPU Low-Power Mode Sequencer

This block is a per-core power sequencer. While the core runs, software programs one of four idle depths into a small mode register. When the core reports that it has executed a wait-for-interrupt instruction, the sequencer gates the core clock and walks through the entry steps for that depth. It then waits for a wake interrupt and restores the core in the reverse order. The four depths are: plain clock-gated standby, retention at reduced voltage, standalone power-down with warm boot, and full power collapse. Full power collapse also announces itself to a system power-manager agent.

The sequencer drives the core clock gate, a retention-voltage request, the core power switch enable and the core reset. It also runs a request/acknowledge pair toward the shared cache hierarchy and a second pair toward the power manager. A cache-standby request is only raised when the cluster reports that every core is idle. Each rail or voltage step dwells for a fixed settle interval. After each sequence the programmed mode falls back to standby. A status port exposes the current step, the last mode run and a sticky handshake error flag.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, state_o is 0 (run), pwr_en_o is 1, and clk_gate_o, ret_req_o, core_rst_o, cache_req_o, pm_req_o, pm_err_o, mode_o and last_mode_o are all 0.
- R2: In run (0), wfi_i high moves state_o to the gate step (1) on the next edge. clk_gate_o is high in every step other than run. The programmed mode is sampled at that edge.
- R3: From the gate step, cache_req_o rises (cache-entry step, 2) only if all_idle_i is high. It then stays high until the cache-exit step (10). That step holds clk_gate_o high until cache_ack_i is low.
- R4: Standby (mode 00) goes from the gate step (and the cache-entry step when used) to the wait step (6). It stays there until irq_i, then passes through the cache-exit step if the cache was requested, and returns to run.
- R5: Retention (mode 01) holds the retention-on step (3) with ret_req_o high for SETTLE_CYC cycles, then waits (6) with ret_req_o still high. On irq_i it enters the retention-off step (9), where ret_req_o is low and the clock stays gated for SETTLE_CYC cycles, before the clock is released.
- R6: Standalone power-down (mode 10) follows this order. Power-off step (5): pwr_en_o low and core_rst_o high for SETTLE_CYC cycles. Wait with power off. Power-on step (7): pwr_en_o high and reset held for SETTLE_CYC cycles. Cache exit if used. Ready step (11) until sys_ready_i. Reset-release step (12) for SETTLE_CYC cycles. Run, with core_rst_o low.
- R7: Power collapse (mode 11) runs only if all_idle_i is high when the sequence starts; otherwise mode 10 is run instead. Its order is: gate, cache entry, pm-entry (4) with pm_req_o high until pm_ack_i, power-off, wait, power-on, pm-exit (8) with pm_req_o high until pm_ack_i, cache exit, ready, reset release, run.
- R8: mode_wr_i loads mode_i into mode_o (00 standby, 01 retention, 10 standalone power-down, 11 power collapse). mode_o returns to 00 on the edge that returns the block to run, and last_mode_o then shows the mode actually run.
- R9: irq_i high in the gate, cache-entry or pm-entry step aborts the entry. The block goes to cache exit if the cache was requested, otherwise straight to run, and pwr_en_o never drops and core_rst_o never rises.
- R10: If pm_ack_i does not arrive within PM_TMO cycles in the pm-entry step, pm_err_o is set and the entry unwinds as in R9. A timeout in the pm-exit step sets pm_err_o and the exit continues. pm_err_o stays set until reset.
- R11: pwr_en_o is low only while core_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Core has executed a wait-for-interrupt instruction |
| irq_i | input | 1 | Wake interrupt |
| all_idle_i | input | 1 | Every core in the cluster is idle |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_i | input | 2 | Mode value to program |
| cache_ack_i | input | 1 | Cache hierarchy standby acknowledge |
| sys_ready_i | input | 1 | Cache/system ready for core restart |
| pm_ack_i | input | 1 | Power-manager acknowledge |
| clk_gate_o | output | 1 | Core clock gate, 1 = gated |
| ret_req_o | output | 1 | Retention-voltage request |
| pwr_en_o | output | 1 | Core power switch enable |
| core_rst_o | output | 1 | Core reset |
| cache_req_o | output | 1 | Cache hierarchy standby request |
| pm_req_o | output | 1 | Power-manager request |
| pm_err_o | output | 1 | Sticky power-manager timeout flag |
| mode_o | output | 2 | Programmed mode |
| last_mode_o | output | 2 | Mode of the last finished sequence |
| state_o | output | 4 | Current sequence step |

## Verification
Every output is decoded from registers that change together with the step register. Each result is therefore due on the same edge that moves state_o, one cycle after the input that caused it: wfi_i, irq_i, an acknowledge, sys_ready_i or the end of a settle interval. The monitor samples on the falling edge. At each change of state_o it pops the next expected step and compares state_o with all six control outputs in that same half cycle. It also counts how many falling edges each step lasted and compares that with SETTLE_CYC for settle steps, 1 for the gate step and PM_TMO for a timed-out pm-entry step. mode_o, last_mode_o and pm_err_o are checked at the falling edge after the return to run, once the revert edge has passed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_RET  = 2'b01,
    MODE_SPC  = 2'b10,
    MODE_PC   = 2'b11
  } lpm_mode_e;

  localparam int unsigned STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN       = 4'd0,
    ST_GATE      = 4'd1,
    ST_CACHE_IN  = 4'd2,
    ST_RET_ON    = 4'd3,
    ST_PM_ENTER  = 4'd4,
    ST_PWR_OFF   = 4'd5,
    ST_WAIT      = 4'd6,
    ST_PWR_ON    = 4'd7,
    ST_PM_EXIT   = 4'd8,
    ST_RET_OFF   = 4'd9,
    ST_CACHE_OUT = 4'd10,
    ST_RDY       = 4'd11,
    ST_RST_REL   = 4'd12
  } lpm_state_e;

  function automatic logic is_settle(lpm_state_e s);
    return (s == ST_RET_ON) || (s == ST_PWR_OFF) || (s == ST_PWR_ON) ||
           (s == ST_RET_OFF) || (s == ST_RST_REL);
  endfunction

endpackage

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // loaded on the entry edge, so the step lasts exactly CYCLES cycles
  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lpm_pm_handshake.sv
module lpm_pm_handshake #(
  parameter int unsigned TMO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  output logic done_o,
  output logic tmo_o
);
  localparam int unsigned CNT_W = (TMO < 2) ? 1 : $clog2(TMO);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!req_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = req_i & ack_i;
  assign tmo_o  = req_i & ~ack_i & (cnt_q == LAST);

endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  lpm_mode_e wdata_i,
  input  logic      revert_i,
  output lpm_mode_e mode_o
);
  lpm_mode_e mode_q;

  // a write on the revert edge wins: it programs the next sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STBY;
    end else if (wr_i) begin
      mode_q <= wdata_i;
    end else if (revert_i) begin
      mode_q <= MODE_STBY;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned PM_TMO     = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wfi_i,
  input  logic               irq_i,
  input  logic               all_idle_i,
  input  logic               mode_wr_i,
  input  logic [1:0]         mode_i,
  input  logic               cache_ack_i,
  input  logic               sys_ready_i,
  input  logic               pm_ack_i,
  output logic               clk_gate_o,
  output logic               ret_req_o,
  output logic               pwr_en_o,
  output logic               core_rst_o,
  output logic               cache_req_o,
  output logic               pm_req_o,
  output logic               pm_err_o,
  output logic [1:0]         mode_o,
  output logic [1:0]         last_mode_o,
  output logic [STATE_W-1:0] state_o
);

  lpm_state_e state_q, state_d;
  lpm_mode_e  act_q, act_d, last_q, prog_mode;
  logic       cached_q, cached_d;
  logic       off_q, off_d;
  logic       err_q, err_set;
  logic       settle_start, settle_done;
  logic       pm_req, pm_done, pm_tmo;
  logic       seq_end;

  lpm_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (settle_start),
    .done_o  (settle_done)
  );

  lpm_pm_handshake #(.TMO(PM_TMO)) u_pm_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pm_req),
    .ack_i  (pm_ack_i),
    .done_o (pm_done),
    .tmo_o  (pm_tmo)
  );

  lpm_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mode_wr_i),
    .wdata_i  (lpm_mode_e'(mode_i)),
    .revert_i (seq_end),
    .mode_o   (prog_mode)
  );

  function automatic lpm_state_e entry_step(lpm_mode_e m);
    unique case (m)
      MODE_STBY: return ST_WAIT;
      MODE_RET:  return ST_RET_ON;
      MODE_SPC:  return ST_PWR_OFF;
      default:   return ST_PM_ENTER;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    err_set = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_i) begin
          state_d = ST_GATE;
          // collapse needs the whole cluster; otherwise power down alone
          act_d   = (prog_mode == MODE_PC && !all_idle_i) ? MODE_SPC : prog_mode;
        end
      end
      ST_GATE: begin
        if (irq_i)           state_d = ST_RUN;
        else if (all_idle_i) state_d = ST_CACHE_IN;
        else                 state_d = entry_step(act_q);
      end
      ST_CACHE_IN: begin
        if (irq_i)            state_d = ST_CACHE_OUT;
        else if (cache_ack_i) state_d = entry_step(act_q);
      end
      ST_RET_ON: begin
        if (settle_done) state_d = ST_WAIT;
      end
      ST_PM_ENTER: begin
        if (irq_i) begin
          state_d = cached_q ? ST_CACHE_OUT : ST_RUN;
        end else if (pm_done) begin
          state_d = ST_PWR_OFF;
        end else if (pm_tmo) begin
          err_set = 1'b1;
          state_d = cached_q ? ST_CACHE_OUT : ST_RUN;
        end
      end
      ST_PWR_OFF: begin
        if (settle_done) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (irq_i) begin
          unique case (act_q)
            MODE_STBY: state_d = cached_q ? ST_CACHE_OUT : ST_RUN;
            MODE_RET:  state_d = ST_RET_OFF;
            default:   state_d = ST_PWR_ON;
          endcase
        end
      end
      ST_PWR_ON: begin
        if (settle_done) begin
          if (act_q == MODE_PC) state_d = ST_PM_EXIT;
          else                  state_d = cached_q ? ST_CACHE_OUT : ST_RDY;
        end
      end
      ST_PM_EXIT: begin
        if (pm_done || pm_tmo) begin
          err_set = pm_tmo;
          state_d = cached_q ? ST_CACHE_OUT : ST_RDY;
        end
      end
      ST_RET_OFF: begin
        if (settle_done) state_d = cached_q ? ST_CACHE_OUT : ST_RUN;
      end
      ST_CACHE_OUT: begin
        if (!cache_ack_i) state_d = off_q ? ST_RDY : ST_RUN;
      end
      ST_RDY: begin
        if (sys_ready_i) state_d = ST_RST_REL;
      end
      ST_RST_REL: begin
        if (settle_done) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_comb begin
    cached_d = cached_q;
    if (state_d == ST_CACHE_IN)                             cached_d = 1'b1;
    else if (state_d == ST_CACHE_OUT || state_d == ST_RUN)  cached_d = 1'b0;
    off_d = off_q;
    if (state_d == ST_PWR_OFF)  off_d = 1'b1;
    else if (state_d == ST_RUN) off_d = 1'b0;
  end

  assign settle_start = (state_d != state_q) && is_settle(state_d);
  assign seq_end      = (state_q != ST_RUN) && (state_d == ST_RUN);
  assign pm_req       = (state_q == ST_PM_ENTER) || (state_q == ST_PM_EXIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      act_q    <= MODE_STBY;
      last_q   <= MODE_STBY;
      cached_q <= 1'b0;
      off_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      act_q    <= act_d;
      cached_q <= cached_d;
      off_q    <= off_d;
      if (err_set) err_q  <= 1'b1;
      if (seq_end) last_q <= act_q;
    end
  end

  assign clk_gate_o  = (state_q != ST_RUN);
  assign ret_req_o   = (act_q == MODE_RET) && (state_q == ST_RET_ON || state_q == ST_WAIT);
  assign pwr_en_o    = !((state_q == ST_PWR_OFF) || (state_q == ST_WAIT && off_q));
  assign core_rst_o  = off_q;
  assign cache_req_o = cached_q;
  assign pm_req_o    = pm_req;
  assign pm_err_o    = err_q;
  assign mode_o      = prog_mode;
  assign last_mode_o = last_q;
  assign state_o     = state_q;

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wfi_i,
  input logic       all_idle_i,
  input logic       mode_wr_i,
  input logic       clk_gate_o,
  input logic       ret_req_o,
  input logic       pwr_en_o,
  input logic       core_rst_o,
  input logic       cache_req_o,
  input logic       pm_req_o,
  input logic       pm_err_o,
  input logic [1:0] mode_o,
  input logic [3:0] state_o
);

  a_r2_gate_on_wfi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0 && wfi_i) |=> (state_o == 4'd1 && clk_gate_o));

  a_r3_cache_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cache_req_o) |-> $past(all_idle_i));

  a_r5_volt_before_ungate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_gate_o) |-> (!ret_req_o && $past(!ret_req_o)));

  a_r6_rst_release_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (state_o == 4'd0 && $past(state_o) == 4'd12));

  a_r7_pm_after_cache: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pm_req_o) |-> cache_req_o);

  a_r8_mode_revert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_gate_o) && !$past(mode_wr_i)) |-> (mode_o == 2'b00));

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_err_o |=> pm_err_o);

  a_r11_off_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> core_rst_o);

endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wfi_i       (wfi_i),
  .all_idle_i  (all_idle_i),
  .mode_wr_i   (mode_wr_i),
  .clk_gate_o  (clk_gate_o),
  .ret_req_o   (ret_req_o),
  .pwr_en_o    (pwr_en_o),
  .core_rst_o  (core_rst_o),
  .cache_req_o (cache_req_o),
  .pm_req_o    (pm_req_o),
  .pm_err_o    (pm_err_o),
  .mode_o      (mode_o),
  .state_o     (state_o)
);

// File: tb/lpm_sequencer_tb_top.sv
module lpm_sequencer_tb_top;

  localparam int unsigned SETTLE = 16;
  localparam int unsigned TMO    = 64;

  // {gate, ret, pwr, rst, cache, pm}
  localparam logic [5:0] O_RUN = 6'b001000;

  typedef struct packed {
    logic [3:0] st;
    logic [5:0] outs;
    logic [7:0] dwell;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wfi_i = 1'b0, irq_i = 1'b0, all_idle_i = 1'b0;
  logic mode_wr_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic cache_ack_i, sys_ready_i = 1'b1, pm_ack_i;
  logic clk_gate_o, ret_req_o, pwr_en_o, core_rst_o, cache_req_o, pm_req_o, pm_err_o;
  logic [1:0] mode_o, last_mode_o;
  logic [3:0] state_o;

  int checks = 0;
  int errors = 0;
  logic cache_en = 1'b1, pm_en = 1'b1, mon_on = 1'b0;
  logic [1:0] c_sh = '0;
  logic [2:0] p_sh = '0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  lpm_sequencer #(.SETTLE_CYC(SETTLE), .PM_TMO(TMO)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wfi_i(wfi_i), .irq_i(irq_i),
    .all_idle_i(all_idle_i), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .cache_ack_i(cache_ack_i), .sys_ready_i(sys_ready_i), .pm_ack_i(pm_ack_i),
    .clk_gate_o(clk_gate_o), .ret_req_o(ret_req_o), .pwr_en_o(pwr_en_o),
    .core_rst_o(core_rst_o), .cache_req_o(cache_req_o), .pm_req_o(pm_req_o),
    .pm_err_o(pm_err_o), .mode_o(mode_o), .last_mode_o(last_mode_o), .state_o(state_o)
  );

  // responders: acknowledge follows request after a fixed delay
  always @(posedge clk_i) begin
    c_sh <= {c_sh[0], cache_req_o & cache_en};
    p_sh <= {p_sh[1:0], pm_req_o & pm_en};
  end
  assign cache_ack_i = c_sh[1];
  assign pm_ack_i    = p_sh[2];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_step(input logic [3:0] s, input logic [5:0] o, input int d, input string tag);
    exp_t e;
    e.st = s; e.outs = o; e.dwell = 8'(d);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  logic [3:0] prev_s = 4'd0;
  int    dwell = 0;
  int    exp_dwell = 0;
  string cur_tag = "R1";
  always @(negedge clk_i) begin
    if (rst_ni && mon_on) begin
      if (state_o == prev_s) begin
        dwell++;
      end else begin
        if (exp_dwell != 0) begin
          checks++;
          if (dwell != exp_dwell) begin
            errors++;
            $display("FAIL %s dwell of step %0d actual=%0d expected=%0d", cur_tag, prev_s, dwell, exp_dwell);
          end
        end
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected step actual=%0d expected=none", cur_tag, state_o);
          exp_dwell = 0;
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (state_o != e.st ||
              {clk_gate_o, ret_req_o, pwr_en_o, core_rst_o, cache_req_o, pm_req_o} != e.outs) begin
            errors++;
            $display("FAIL %s step/outs actual=%0d/%b expected=%0d/%b", t, state_o,
                     {clk_gate_o, ret_req_o, pwr_en_o, core_rst_o, cache_req_o, pm_req_o}, e.st, e.outs);
          end
          exp_dwell = int'(e.dwell);
          cur_tag   = t;
        end
        prev_s = state_o;
        dwell  = 1;
      end
    end
  end

  // tracks power or reset activity during aborted entries (R9)
  logic pwr_dropped = 1'b0;
  always @(negedge clk_i) if (mon_on && (!pwr_en_o || core_rst_o)) pwr_dropped = 1'b1;

  task automatic wait_step(input logic [3:0] s);
    do @(negedge clk_i); while (state_o != s);
  endtask

  task automatic prog_mode(input logic [1:0] m);
    @(negedge clk_i); mode_i = m; mode_wr_i = 1'b1;
    @(negedge clk_i); mode_wr_i = 1'b0;
    chk("R8 mode_o after write", int'(mode_o), int'(m));
  endtask

  task automatic pulse_wfi();
    @(negedge clk_i); wfi_i = 1'b1;
    @(negedge clk_i); wfi_i = 1'b0;
  endtask

  task automatic wake_at_wait();
    wait_step(4'd6);
    repeat (3) @(negedge clk_i);
    irq_i = 1'b1;
  endtask

  task automatic finish_seq(input string tag, input int last);
    wait_step(4'd0);
    irq_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk({tag, " all steps seen"}, exp_q.size(), 0);
    chk("R8 mode reverted", int'(mode_o), 0);
    chk("R8 last_mode_o", int'(last_mode_o), last);
  endtask

  task automatic deep_exit();
    wait_step(4'd11);
    repeat (3) @(negedge clk_i);
    sys_ready_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 state_o", int'(state_o), 0);
    chk("R1 outputs", int'({clk_gate_o, ret_req_o, pwr_en_o, core_rst_o, cache_req_o, pm_req_o}), int'(O_RUN));
    chk("R1 pm_err_o", int'(pm_err_o), 0);
    chk("R1 mode_o", int'(mode_o), 0);
    chk("R1 last_mode_o", int'(last_mode_o), 0);
    mon_on = 1'b1;

    // R2 R4 standby without cache
    all_idle_i = 1'b0;
    expect_step(4'd1, 6'b101000, 1, "R2");
    expect_step(4'd6, 6'b101000, 0, "R4");
    expect_step(4'd0, O_RUN,     0, "R4");
    pulse_wfi();
    wake_at_wait();
    finish_seq("R4", 0);

    // R3 R4 standby with cache standby
    all_idle_i = 1'b1;
    expect_step(4'd1,  6'b101000, 1, "R2");
    expect_step(4'd2,  6'b101010, 0, "R3");
    expect_step(4'd6,  6'b101010, 0, "R4");
    expect_step(4'd10, 6'b101000, 0, "R3");
    expect_step(4'd0,  O_RUN,     0, "R4");
    pulse_wfi();
    wake_at_wait();
    finish_seq("R3", 0);

    // R5 retention
    all_idle_i = 1'b0;
    prog_mode(2'b01);
    expect_step(4'd1, 6'b101000, 1,      "R2");
    expect_step(4'd3, 6'b111000, SETTLE, "R5");
    expect_step(4'd6, 6'b111000, 0,      "R5");
    expect_step(4'd9, 6'b101000, SETTLE, "R5");
    expect_step(4'd0, O_RUN,     0,      "R5");
    pulse_wfi();
    wake_at_wait();
    finish_seq("R5", 1);

    // R6 standalone power-down
    prog_mode(2'b10);
    sys_ready_i = 1'b0;
    expect_step(4'd1,  6'b101000, 1,      "R2");
    expect_step(4'd5,  6'b100100, SETTLE, "R6");
    expect_step(4'd6,  6'b100100, 0,      "R6");
    expect_step(4'd7,  6'b101100, SETTLE, "R6");
    expect_step(4'd11, 6'b101100, 0,      "R6");
    expect_step(4'd12, 6'b101100, SETTLE, "R6");
    expect_step(4'd0,  O_RUN,     0,      "R6");
    pulse_wfi();
    wake_at_wait();
    deep_exit();
    finish_seq("R6", 2);

    // R7 full power collapse
    all_idle_i = 1'b1;
    prog_mode(2'b11);
    sys_ready_i = 1'b0;
    expect_step(4'd1,  6'b101000, 1,      "R2");
    expect_step(4'd2,  6'b101010, 0,      "R3");
    expect_step(4'd4,  6'b101011, 0,      "R7");
    expect_step(4'd5,  6'b100110, SETTLE, "R7");
    expect_step(4'd6,  6'b100110, 0,      "R7");
    expect_step(4'd7,  6'b101110, SETTLE, "R7");
    expect_step(4'd8,  6'b101111, 0,      "R7");
    expect_step(4'd10, 6'b101100, 0,      "R7");
    expect_step(4'd11, 6'b101100, 0,      "R7");
    expect_step(4'd12, 6'b101100, SETTLE, "R7");
    expect_step(4'd0,  O_RUN,     0,      "R7");
    pulse_wfi();
    wake_at_wait();
    deep_exit();
    finish_seq("R7", 3);
    chk("R10 no error after good handshakes", int'(pm_err_o), 0);

    // R7 collapse demoted when the cluster is not idle
    all_idle_i = 1'b0;
    prog_mode(2'b11);
    sys_ready_i = 1'b0;
    expect_step(4'd1,  6'b101000, 1,      "R7");
    expect_step(4'd5,  6'b100100, SETTLE, "R7");
    expect_step(4'd6,  6'b100100, 0,      "R7");
    expect_step(4'd7,  6'b101100, SETTLE, "R7");
    expect_step(4'd11, 6'b101100, 0,      "R7");
    expect_step(4'd12, 6'b101100, SETTLE, "R7");
    expect_step(4'd0,  O_RUN,     0,      "R7");
    pulse_wfi();
    wake_at_wait();
    deep_exit();
    finish_seq("R7", 2);

    // R9 abort during cache entry: power kept
    all_idle_i = 1'b1;
    cache_en = 1'b0;
    prog_mode(2'b10);
    pwr_dropped = 1'b0;
    expect_step(4'd1,  6'b101000, 1, "R9");
    expect_step(4'd2,  6'b101010, 0, "R9");
    expect_step(4'd10, 6'b101000, 1, "R9");
    expect_step(4'd0,  O_RUN,     0, "R9");
    pulse_wfi();
    wait_step(4'd2);
    irq_i = 1'b1;
    finish_seq("R9", 2);
    chk("R9 power and reset untouched", int'(pwr_dropped), 0);
    cache_en = 1'b1;

    // R10 power-manager timeout on entry
    pm_en = 1'b0;
    prog_mode(2'b11);
    pwr_dropped = 1'b0;
    expect_step(4'd1,  6'b101000, 1,   "R10");
    expect_step(4'd2,  6'b101010, 0,   "R10");
    expect_step(4'd4,  6'b101011, TMO, "R10");
    expect_step(4'd10, 6'b101000, 0,   "R10");
    expect_step(4'd0,  O_RUN,     0,   "R10");
    pulse_wfi();
    finish_seq("R10", 3);
    chk("R10 pm_err_o set", int'(pm_err_o), 1);
    chk("R10 power kept", int'(pwr_dropped), 0);
    pm_en = 1'b1;

    // R10 error stays through a later clean standby sequence
    all_idle_i = 1'b0;
    expect_step(4'd1, 6'b101000, 1, "R10");
    expect_step(4'd6, 6'b101000, 0, "R10");
    expect_step(4'd0, O_RUN,     0, "R10");
    pulse_wfi();
    wake_at_wait();
    finish_seq("R10", 0);
    chk("R10 pm_err_o sticky", int'(pm_err_o), 1);

    // R11 is covered by the power/reset pairs compared in every step above
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule